// File: doc/BRIEF.md
# Rising-Edge Phase and Frequency Comparator

This block compares an external logic signal A against an internal reference B and tells a following loop which way to steer. Only the rising edges of the two signals matter: a rising edge on A that arrives before the matching rising edge on B makes the block drive its output high until B catches up. A rising edge on B that comes first makes it drive low until A arrives. Between those intervals the output is released, and a lock flag is raised.

When the two signals run at different frequencies, the faster signal keeps getting a second rising edge before the slower one produces its first. The extra edges leave the output where it is. The result is that a faster A keeps the output high, or released, and never low, and a faster B does the reverse. The block is fully synchronous. Both inputs pass through a synchronizer and a rising-edge detector in the system clock. The three-level output is given as a drive value plus a drive enable, so that a pad or a charge pump outside the block can turn it into a real high-impedance drive.

The controller has three named states:
- RELEASED: no drive, lock flag set.
- PUMP_UP: driving high.
- PUMP_DN: driving low.

Its transitions are named as follows:
- LEAD_A: RELEASED to PUMP_UP on an A edge alone.
- LEAD_B: RELEASED to PUMP_DN on a B edge alone.
- CATCH_B: PUMP_UP to RELEASED on a B edge.
- CATCH_A: PUMP_DN to RELEASED on an A edge.
- EXTRA_A: PUMP_UP holds on an A edge alone.
- EXTRA_B: PUMP_DN holds on a B edge alone.
- TIE: any state goes to RELEASED when both edges are seen in the same cycle.

Top module: `edge_phase_cmp`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `drive_en`=0, `drive_val`=0 and `lock_det`=1 (the RELEASED state).
- R2: Only rising edges of `sig_a` or `sig_b` change the outputs. Falling edges, steady levels and the duty cycle of either input have no effect.
- R3: From RELEASED, an A rising edge alone gives `drive_en`=1 and `drive_val`=1. This holds until a B rising edge returns the block to RELEASED.
- R4: From RELEASED, a B rising edge alone gives `drive_en`=1 and `drive_val`=0. This holds until an A rising edge returns the block to RELEASED.
- R5: While driving high, further A rising edges leave the output unchanged. While driving low, further B rising edges leave the output unchanged.
- R6: A and B rising edges detected in the same clock cycle move the block to RELEASED from any state.
- R7: `lock_det` is 1 exactly when `drive_en` is 0.
- R8: `drive_val` is 0 whenever `drive_en` is 0.
- R9: An input level change applied between clock edges shows at the outputs after the third following rising clock edge, and not after the second (SYNC_STAGES+1 edges).
- R10: If A has a higher frequency than B and the first A edge precedes the first B edge, the block never drives low. In the mirrored case it never drives high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sig_a | input | 1 | External compared signal A, asynchronous |
| sig_b | input | 1 | Reference signal B, asynchronous |
| drive_val | output | 1 | Drive level: 1 for high, 0 for low; 0 when released |
| drive_en | output | 1 | 1 while the output is driven, 0 when released |
| lock_det | output | 1 | 1 while released (lock indication) |

## Verification
A wrong controller state is never hidden. Each of the three states has its own output code, so a bad state or a bad transition appears on the three outputs at the first sample after the clock edge that took it. That is exactly SYNC_STAGES+1 edges after the input edge that caused it. A lost or doubled edge in the detector shows up the same way, as a missing transition or a wrong hold. A sweep over periods, phases and duty cycles compares every cycle against a bench reference model. Because errors show immediately, a single wrong step is caught in the cycle it occurs.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_RELEASED = 2'b00,
        ST_PUMP_UP  = 2'b01,
        ST_PUMP_DN  = 2'b10
    } pfd_state_e;

    typedef struct packed {
        logic en;
        logic val;
        logic lock;
    } pfd_drive_t;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int CHANNELS = 2,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] din,
    output logic [CHANNELS-1:0] rise
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        logic [STAGES-1:0] stg;
        logic              seen;

        always_ff @(posedge clk) begin
            if (rst) begin
                stg  <= '0;
                seen <= 1'b0;
            end else begin
                stg[0] <= din[g];
                for (int k = 1; k < STAGES; k++) begin
                    stg[k] <= stg[k-1];
                end
                seen <= stg[LAST];
            end
        end

        assign rise[g] = stg[LAST] & ~seen;
    end

endmodule

// File: rtl/pfd_state_ctl.sv
module pfd_state_ctl
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       a_rise,
    input  logic       b_rise,
    output pfd_state_e state
);
    pfd_state_e nxt;
    logic [1:0] ev;

    assign ev = {a_rise, b_rise};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RELEASED;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RELEASED: begin
                if (ev == 2'b10)      nxt = ST_PUMP_UP;   // LEAD_A
                else if (ev == 2'b01) nxt = ST_PUMP_DN;   // LEAD_B
                else                  nxt = ST_RELEASED;  // TIE or idle
            end
            ST_PUMP_UP: begin
                if (b_rise)           nxt = ST_RELEASED;  // CATCH_B or TIE
                else                  nxt = ST_PUMP_UP;   // EXTRA_A or idle
            end
            ST_PUMP_DN: begin
                if (a_rise)           nxt = ST_RELEASED;  // CATCH_A or TIE
                else                  nxt = ST_PUMP_DN;   // EXTRA_B or idle
            end
            default:                  nxt = ST_RELEASED;
        endcase
    end

endmodule

// File: rtl/pfd_drive_enc.sv
module pfd_drive_enc
    import pfd_pkg::*;
(
    input  pfd_state_e state,
    output pfd_drive_t drv
);
    always_comb begin
        unique case (state)
            ST_PUMP_UP: drv = '{en: 1'b1, val: 1'b1, lock: 1'b0};
            ST_PUMP_DN: drv = '{en: 1'b1, val: 1'b0, lock: 1'b0};
            default:    drv = '{en: 1'b0, val: 1'b0, lock: 1'b1};
        endcase
    end

endmodule

// File: rtl/edge_phase_cmp.sv
module edge_phase_cmp
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_a,
    input  logic sig_b,
    output logic drive_val,
    output logic drive_en,
    output logic lock_det
);
    localparam int NCH = 2;

    logic [NCH-1:0] rise_vec;
    logic           a_rise;
    logic           b_rise;
    pfd_state_e     state;
    pfd_drive_t     drv;

    pfd_edge_sync #(
        .CHANNELS (NCH),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sig_b, sig_a}),
        .rise (rise_vec)
    );

    assign a_rise = rise_vec[0];
    assign b_rise = rise_vec[1];

    pfd_state_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .a_rise (a_rise),
        .b_rise (b_rise),
        .state  (state)
    );

    pfd_drive_enc u_enc (
        .state (state),
        .drv   (drv)
    );

    assign drive_en  = drv.en;
    assign drive_val = drv.val;
    assign lock_det  = drv.lock;

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
    input logic clk,
    input logic rst,
    input logic a_rise,
    input logic b_rise,
    input logic drive_val,
    input logic drive_en,
    input logic lock_det
);
    AST_RESET_RELEASED: assert property (@(posedge clk)
        rst |=> (lock_det && !drive_en && !drive_val)); // R1

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!a_rise && !b_rise) |=> $stable({drive_en, drive_val, lock_det})); // R2

    AST_LEAD_A_UP: assert property (@(posedge clk) disable iff (rst)
        (lock_det && a_rise && !b_rise) |=> (drive_en && drive_val)); // R3

    AST_LEAD_B_DN: assert property (@(posedge clk) disable iff (rst)
        (lock_det && b_rise && !a_rise) |=> (drive_en && !drive_val)); // R4

    AST_UP_NEVER_DN: assert property (@(posedge clk) disable iff (rst)
        (drive_en && drive_val) |=> (!drive_en || drive_val)); // R5

    AST_DN_NEVER_UP: assert property (@(posedge clk) disable iff (rst)
        (drive_en && !drive_val) |=> (!drive_en || !drive_val)); // R5

    AST_TIE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (a_rise && b_rise) |=> lock_det); // R6

    AST_LOCK_MATCH: assert property (@(posedge clk) disable iff (rst)
        lock_det == !drive_en); // R7

    AST_VAL_GATED: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> !drive_val); // R8

endmodule

bind edge_phase_cmp pfd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_rise    (a_rise),
    .b_rise    (b_rise),
    .drive_val (drive_val),
    .drive_en  (drive_en),
    .lock_det  (lock_det)
);

// File: tb/sim_edge_phase_cmp.sv
`timescale 1ns/1ps
module sim_edge_phase_cmp;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_a = 1'b0;
    logic sig_b = 1'b0;
    logic drive_val, drive_en, lock_det;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [2:0] E_REL = 3'b001;  // {en,val,lock}
    localparam logic [2:0] E_UP  = 3'b110;
    localparam logic [2:0] E_DN  = 3'b100;

    always #2 clk = ~clk;

    edge_phase_cmp u0 (
        .clk       (clk),
        .rst       (rst),
        .sig_a     (sig_a),
        .sig_b     (sig_b),
        .drive_val (drive_val),
        .drive_en  (drive_en),
        .lock_det  (lock_det)
    );

    function automatic logic [2:0] obs();
        return {drive_en, drive_val, lock_det};
    endfunction

    task automatic chk(input logic [2:0] got, input logic [2:0] exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got en/val/lock=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sig_a = 1'b0; sig_b = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [2:0] step(input logic [2:0] m, input bit ra, input bit rb);
        if (ra && rb) return E_REL;
        if (m == E_REL) return ra ? E_UP : (rb ? E_DN : E_REL);
        if (m == E_UP)  return rb ? E_REL : E_UP;
        return ra ? E_REL : E_DN;
    endfunction

    task automatic sweep(input int pa, input int pb, input int ph, input int ncyc);
        logic [2:0] m, d1, d2, d3;
        bit ap, bp, al, bl;
        int ha, hb;
        ha = 1 + (ph % (pa - 1));
        hb = 1 + ((ph + 1) % (pb - 1));
        do_reset();
        m = E_REL; d1 = E_REL; d2 = E_REL; d3 = E_REL;
        ap = 1'b0; bp = 1'b0;
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            chk(obs(), d3, "R2 R3 R4 R5 R6 R7 R8 sweep");
            al = ((t + ph) % pa) < ha;
            bl = (t % pb) < hb;
            m = step(m, al && !ap, bl && !bp);
            ap = al; bp = bl;
            d3 = d2; d2 = d1; d1 = m;
            sig_a = al; sig_b = bl;
        end
    endtask

    task automatic freq_run(input int pa, input int pb, input bit expect_up);
        int up_n, dn_n;
        up_n = 0; dn_n = 0;
        do_reset();
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (drive_en && drive_val)  up_n++;
            if (drive_en && !drive_val) dn_n++;
            sig_a = (t % pa) < (pa / 2);
            sig_b = (t % pb) < (pb / 2);
        end
        tests++;
        if (expect_up ? (dn_n != 0 || up_n == 0) : (up_n != 0 || dn_n == 0)) begin
            fails++;
            $display("FAIL R10: up=%0d dn=%0d expected %s only", up_n, dn_n,
                     expect_up ? "up" : "down");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk(obs(), E_REL, "R1 reset state");

        // R9: latency of an A edge, then R3 hold
        sig_a = 1'b1;
        repeat (2) @(negedge clk);
        chk(obs(), E_REL, "R9 no change after 2 edges");
        @(negedge clk);
        chk(obs(), E_UP, "R9 R3 drive high after 3 edges");

        // R2: falling A edge ignored
        sig_a = 1'b0; settle();
        chk(obs(), E_UP, "R2 falling A ignored");

        // R5: extra A edge holds high
        sig_a = 1'b1; settle();
        chk(obs(), E_UP, "R5 extra A holds high");

        // R3: B edge releases
        sig_b = 1'b1; settle();
        chk(obs(), E_REL, "R3 B edge releases");
        chk(obs(), E_REL, "R7 lock while released");

        // R2: falling B ignored while released
        sig_b = 1'b0; settle();
        chk(obs(), E_REL, "R2 falling B ignored");

        // R4: B leads
        sig_b = 1'b1; settle();
        chk(obs(), E_DN, "R4 B edge drives low");
        sig_b = 1'b0; settle();
        sig_b = 1'b1; settle();
        chk(obs(), E_DN, "R5 extra B holds low");
        sig_a = 1'b0; settle();
        chk(obs(), E_DN, "R2 falling A ignored while low");
        sig_a = 1'b1; settle();
        chk(obs(), E_REL, "R4 A edge releases");

        // R6: simultaneous edges from RELEASED, PUMP_UP, PUMP_DN
        sig_a = 1'b0; sig_b = 1'b0; settle();
        sig_a = 1'b1; sig_b = 1'b1; settle();
        chk(obs(), E_REL, "R6 tie from released");
        sig_a = 1'b0; sig_b = 1'b0; settle();
        sig_a = 1'b1; settle();
        chk(obs(), E_UP, "R3 setup for tie");
        sig_a = 1'b0; settle();
        sig_a = 1'b1; sig_b = 1'b1; settle();
        chk(obs(), E_REL, "R6 tie from high");
        sig_a = 1'b0; sig_b = 1'b0; settle();
        sig_b = 1'b1; settle();
        chk(obs(), E_DN, "R4 setup for tie");
        sig_b = 1'b0; settle();
        sig_a = 1'b1; sig_b = 1'b1; settle();
        chk(obs(), E_REL, "R6 tie from low");

        // R1: reset from a driving state
        sig_a = 1'b0; sig_b = 1'b0; settle();
        sig_a = 1'b1; settle();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(obs(), E_REL, "R1 reset from high");
        rst = 1'b0; sig_a = 1'b0;

        // R10: frequency difference
        freq_run(5, 9, 1'b1);
        freq_run(9, 5, 1'b0);

        // near-exhaustive sweep of periods, phase and duty cycle
        for (int pa = 3; pa <= 7; pa++)
            for (int pb = 3; pb <= 7; pb++)
                for (int ph = 0; ph < 3; ph++)
                    sweep(pa, pb, ph, 48);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule